// File: doc/BRIEF.md
# Loop-Closing Branch Predictor

This block makes a direction guess for conditional branches in a pipelined core. It keeps exactly one remembered branch: the most recent taken branch whose target lies below its own address. That is the branch that closes a loop. The fetch or decode stage presents an instruction address on the lookup port. The block answers in the same cycle with a predicted-taken flag and the remembered target, so fetch can redirect on a hit.

When a conditional branch resolves, the pipeline reports its address, its target and whether it was taken. The block works out what it would have predicted for that branch from the entry as it stood before the update. It pulses a mispredict flag in that cycle when the outcome disagrees, which stands for the single stall cycle the pipeline pays. On the next clock edge it then fills, clears or keeps its entry.

Top module: `loop_branch_predictor`

## Requirements
- R1: After synchronous reset the entry is empty, so `lk_taken` is 0 for every lookup address.
- R2: `lk_taken` is 1 exactly when the entry is valid and `lk_pc` equals the stored branch address in all XLEN bits. An address that differs in any bit, bit 31 included, misses.
- R3: In a cycle with `res_valid` = 1, `res_mispredict` is 1 exactly when `res_taken` differs from the prediction for `res_pc`. That prediction is taken from the entry as it stood before this resolution. A correct taken or not-taken guess gives 0.
- R4: A resolution with `res_taken` = 1 and `res_target` < `res_pc` (unsigned) makes the entry valid on the next edge, holding that `res_pc` and `res_target`. Any earlier entry is replaced.
- R5: A resolution with `res_taken` = 0 for a branch that was predicted taken clears the entry on the next edge.
- R6: A taken branch with `res_target` >= `res_pc`, equality included, leaves the entry unchanged.
- R7: A not-taken branch that was predicted not taken leaves the entry unchanged.
- R8: Entry updates appear one clock edge after the resolution. A lookup in the resolving cycle sees the old entry.
- R9: While `res_valid` = 0 the entry does not change and `res_mispredict` stays 0, whatever the other resolve inputs carry.
- R10: While `lk_taken` = 1, `lk_target` equals the target stored with the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | XLEN | Address being looked up by fetch/decode |
| lk_taken | output | 1 | Predicted taken for `lk_pc` |
| lk_target | output | XLEN | Stored target, meaningful when `lk_taken` is 1 |
| res_valid | input | 1 | A conditional branch resolves this cycle |
| res_pc | input | XLEN | Address of the resolving branch |
| res_target | input | XLEN | Target of the resolving branch |
| res_taken | input | 1 | Actual outcome of the resolving branch |
| res_mispredict | output | 1 | One-cycle pulse: the outcome differed from the prediction |

## Verification
The bound checker watches the entry register cycle by cycle. It confirms the fill on backward taken branches, the clear after a wrong taken guess, and that the entry holds for forward taken branches, agreeing not-taken branches and idle cycles. It also confirms that a hit always points at the stored address and that the mispredict flag never fires outside a resolve cycle. Other behaviour can only be shown by the bench's sequences. These are that the old entry is still seen in the resolving cycle, that a later backward branch evicts an earlier one, the equal-target corner and a high-bit address mismatch. A long random run against a reference model checks how mispredict counts add up over mixed loops.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

  // What the single entry does on the next clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_FILL  = 2'd1,
    ACT_CLEAR = 2'd2
  } lbp_action_e;

endpackage

// File: rtl/lbp_match.sv
module lbp_match #(
  parameter int XLEN = 32
) (
  input  logic            ent_valid,
  input  logic [XLEN-1:0] ent_pc,
  input  logic [XLEN-1:0] probe_pc,
  output logic            hit
);

  // Full-width compare; no alignment bits are dropped.
  always_comb begin
    hit = ent_valid && (probe_pc == ent_pc);
  end

endmodule

// File: rtl/lbp_policy.sv
module lbp_policy #(
  parameter int XLEN = 32
) (
  input  logic                res_valid,
  input  logic [XLEN-1:0]     res_pc,
  input  logic [XLEN-1:0]     res_target,
  input  logic                res_taken,
  input  logic                guess_taken,
  output lbp_pkg::lbp_action_e action,
  output logic                mispredict
);

  import lbp_pkg::*;

  logic backward;

  always_comb begin
    backward   = res_target < res_pc;
    mispredict = res_valid && (res_taken != guess_taken);
    action     = ACT_HOLD;
    if (res_valid) begin
      if (res_taken && backward) begin
        action = ACT_FILL;
      end else if (!res_taken && guess_taken) begin
        action = ACT_CLEAR;
      end
    end
  end

endmodule

// File: rtl/lbp_entry.sv
module lbp_entry #(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  lbp_pkg::lbp_action_e action,
  input  logic [XLEN-1:0]      new_pc,
  input  logic [XLEN-1:0]      new_target,
  output logic                 ent_valid,
  output logic [XLEN-1:0]      ent_pc,
  output logic [XLEN-1:0]      ent_target
);

  import lbp_pkg::*;

  // Only the valid bit takes reset; address fields are plain data.
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= 1'b0;
    end else begin
      case (action)
        ACT_FILL:  ent_valid <= 1'b1;
        ACT_CLEAR: ent_valid <= 1'b0;
        default:   ent_valid <= ent_valid;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (action == ACT_FILL) begin
      ent_pc     <= new_pc;
      ent_target <= new_target;
    end
  end

endmodule

// File: rtl/loop_branch_predictor.sv
module loop_branch_predictor #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] lk_pc,
  output logic            lk_taken,
  output logic [XLEN-1:0] lk_target,
  input  logic            res_valid,
  input  logic [XLEN-1:0] res_pc,
  input  logic [XLEN-1:0] res_target,
  input  logic            res_taken,
  output logic            res_mispredict
);

  import lbp_pkg::*;

  logic            ent_valid;
  logic [XLEN-1:0] ent_pc;
  logic [XLEN-1:0] ent_tgt;
  logic            res_guess;
  lbp_action_e     action;

  lbp_entry #(.XLEN(XLEN)) entry_i (
    .clk        (clk),
    .rst        (rst),
    .action     (action),
    .new_pc     (res_pc),
    .new_target (res_target),
    .ent_valid  (ent_valid),
    .ent_pc     (ent_pc),
    .ent_target (ent_tgt)
  );

  // Front-end lookup port.
  lbp_match #(.XLEN(XLEN)) fetch_match_i (
    .ent_valid (ent_valid),
    .ent_pc    (ent_pc),
    .probe_pc  (lk_pc),
    .hit       (lk_taken)
  );

  // Re-derive the guess for the resolving branch from the pre-update entry.
  lbp_match #(.XLEN(XLEN)) resolve_match_i (
    .ent_valid (ent_valid),
    .ent_pc    (ent_pc),
    .probe_pc  (res_pc),
    .hit       (res_guess)
  );

  lbp_policy #(.XLEN(XLEN)) policy_i (
    .res_valid   (res_valid),
    .res_pc      (res_pc),
    .res_target  (res_target),
    .res_taken   (res_taken),
    .guess_taken (res_guess),
    .action      (action),
    .mispredict  (res_mispredict)
  );

  assign lk_target = ent_tgt;

endmodule

// File: rtl/lbp_checker.sv
module lbp_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] lk_pc,
  input logic            lk_taken,
  input logic            res_valid,
  input logic [XLEN-1:0] res_pc,
  input logic [XLEN-1:0] res_target,
  input logic            res_taken,
  input logic            res_mispredict,
  input logic            ent_valid,
  input logic [XLEN-1:0] ent_pc,
  input logic [XLEN-1:0] ent_tgt
);

  logic hit_res;
  assign hit_res = ent_valid && (ent_pc == res_pc);

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !ent_valid && !lk_taken);

  assert_hit_matches_entry_R2: assert property (@(posedge clk) disable iff (rst)
    lk_taken |-> ent_valid && (lk_pc == ent_pc));

  assert_correct_taken_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_taken && hit_res |-> !res_mispredict);

  assert_backward_fill_R4: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_taken && (res_target < res_pc)
    |=> ent_valid && (ent_pc == $past(res_pc)) && (ent_tgt == $past(res_target)));

  assert_wrong_guess_clears_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_taken && hit_res |=> !ent_valid);

  assert_forward_holds_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_taken && (res_target >= res_pc)
    |=> $stable(ent_valid) && $stable(ent_pc) && $stable(ent_tgt));

  assert_agree_nt_holds_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_taken && !hit_res
    |=> $stable(ent_valid) && $stable(ent_pc) && $stable(ent_tgt));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> $stable(ent_valid) && $stable(ent_pc) && $stable(ent_tgt));

  assert_no_pulse_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !res_mispredict);

endmodule

bind loop_branch_predictor lbp_checker #(.XLEN(XLEN)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .lk_pc          (lk_pc),
  .lk_taken       (lk_taken),
  .res_valid      (res_valid),
  .res_pc         (res_pc),
  .res_target     (res_target),
  .res_taken      (res_taken),
  .res_mispredict (res_mispredict),
  .ent_valid      (ent_valid),
  .ent_pc         (ent_pc),
  .ent_tgt        (ent_tgt)
);

// File: tb/loop_branch_predictor_tb_top.sv
module loop_branch_predictor_tb_top;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [XLEN-1:0] lk_pc = '0;
  logic            lk_taken;
  logic [XLEN-1:0] lk_target;
  logic            res_valid = 1'b0;
  logic [XLEN-1:0] res_pc = '0;
  logic [XLEN-1:0] res_target = '0;
  logic            res_taken = 1'b0;
  logic            res_mispredict;

  int n_checks = 0;
  int n_fail   = 0;

  // Reference model state
  logic            m_valid = 1'b0;
  logic [XLEN-1:0] m_pc = '0;
  logic [XLEN-1:0] m_tgt = '0;

  // Last observed outputs
  logic            o_hit;
  logic [XLEN-1:0] o_tgt;
  logic            o_mis;

  always #5 clk = ~clk;

  loop_branch_predictor #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_target(lk_target), .res_valid(res_valid), .res_pc(res_pc),
    .res_target(res_target), .res_taken(res_taken),
    .res_mispredict(res_mispredict)
  );

  function automatic logic f_hit(logic [XLEN-1:0] pc);
    return m_valid && (pc == m_pc);
  endfunction

  function automatic logic f_mis(logic rv, logic [XLEN-1:0] pc, logic tk);
    return rv && (tk != f_hit(pc));
  endfunction

  task automatic check(logic ok, string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare combinational outputs, then let the edge update.
  task automatic step(logic [XLEN-1:0] lpc, logic rv, logic [XLEN-1:0] rpc,
                      logic [XLEN-1:0] rtgt, logic rtk);
    logic e_hit, e_mis;
    @(negedge clk);
    lk_pc = lpc; res_valid = rv; res_pc = rpc; res_target = rtgt; res_taken = rtk;
    #1;
    e_hit = f_hit(lpc);
    e_mis = f_mis(rv, rpc, rtk);
    o_hit = lk_taken; o_tgt = lk_target; o_mis = res_mispredict;
    check(o_hit == e_hit, "R2", {31'd0, o_hit}, {31'd0, e_hit});
    if (e_hit) check(o_tgt == m_tgt, "R10", o_tgt, m_tgt);
    check(o_mis == e_mis, "R3", {31'd0, o_mis}, {31'd0, e_mis});
    @(posedge clk);
    if (rv) begin
      if (rtk && (rtgt < rpc)) begin
        m_valid = 1'b1; m_pc = rpc; m_tgt = rtgt;
      end else if (!rtk && e_mis) begin
        m_valid = 1'b0;
      end
    end
  endtask

  task automatic probe(logic [XLEN-1:0] lpc);
    step(lpc, 1'b0, 32'h0000_0800, 32'h0000_0010, 1'b1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] pool [8];
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: empty after reset
    probe(32'h0000_0100);
    check(o_hit == 1'b0, "R1", {31'd0, o_hit}, 32'd0);
    probe(32'h0000_0000);
    check(o_hit == 1'b0, "R1", {31'd0, o_hit}, 32'd0);

    // R4: backward taken fills
    step(32'h0, 1'b1, 32'h0000_0200, 32'h0000_01F0, 1'b1);
    probe(32'h0000_0200);
    check(o_hit == 1'b1, "R4", {31'd0, o_hit}, 32'd1);
    check(o_tgt == 32'h0000_01F0, "R4", o_tgt, 32'h0000_01F0);
    // R4: replacement
    step(32'h0, 1'b1, 32'h0000_0300, 32'h0000_0280, 1'b1);
    probe(32'h0000_0200);
    check(o_hit == 1'b0, "R4", {31'd0, o_hit}, 32'd0);
    probe(32'h0000_0300);
    check(o_hit == 1'b1, "R4", {31'd0, o_hit}, 32'd1);

    // R6: equal target is forward
    step(32'h0, 1'b1, 32'h0000_0400, 32'h0000_0400, 1'b1);
    check(o_mis == 1'b1, "R3", {31'd0, o_mis}, 32'd1);
    probe(32'h0000_0400);
    check(o_hit == 1'b0, "R6", {31'd0, o_hit}, 32'd0);
    probe(32'h0000_0300);
    check(o_hit == 1'b1, "R6", {31'd0, o_hit}, 32'd1);

    // R8: lookup in resolving cycle sees old entry
    step(32'h0000_0500, 1'b1, 32'h0000_0500, 32'h0000_0010, 1'b1);
    check(o_hit == 1'b0, "R8", {31'd0, o_hit}, 32'd0);
    probe(32'h0000_0500);
    check(o_hit == 1'b1, "R8", {31'd0, o_hit}, 32'd1);

    // R5: predicted taken, falls through
    step(32'h0, 1'b1, 32'h0000_0500, 32'h0000_0010, 1'b0);
    check(o_mis == 1'b1, "R3", {31'd0, o_mis}, 32'd1);
    probe(32'h0000_0500);
    check(o_hit == 1'b0, "R5", {31'd0, o_hit}, 32'd0);

    // R7: agreeing not-taken keeps entry
    step(32'h0, 1'b1, 32'h0000_0600, 32'h0000_0580, 1'b1);
    step(32'h0, 1'b1, 32'h0000_0700, 32'h0000_0100, 1'b0);
    check(o_mis == 1'b0, "R7", {31'd0, o_mis}, 32'd0);
    probe(32'h0000_0600);
    check(o_hit == 1'b1, "R7", {31'd0, o_hit}, 32'd1);

    // R9: idle resolve inputs ignored (probe drives taken backward data)
    probe(32'h0000_0800);
    check(o_mis == 1'b0, "R9", {31'd0, o_mis}, 32'd0);
    check(o_hit == 1'b0, "R9", {31'd0, o_hit}, 32'd0);
    probe(32'h0000_0600);
    check(o_hit == 1'b1, "R9", {31'd0, o_hit}, 32'd1);

    // R2: full-address compare
    probe(32'h8000_0600);
    check(o_hit == 1'b0, "R2", {31'd0, o_hit}, 32'd0);

    // R3: correct taken guess costs nothing
    step(32'h0, 1'b1, 32'h0000_0600, 32'h0000_0580, 1'b1);
    check(o_mis == 1'b0, "R3", {31'd0, o_mis}, 32'd0);
    check(m_valid == 1'b1, "R10", {31'd0, m_valid}, 32'd1);

    // Constrained random loops against the model
    void'($urandom(32'd12345));
    for (int i = 0; i < 8; i++) pool[i] = 32'h0000_1000 + (i << 6);
    for (int i = 0; i < 4000; i++) begin
      logic [XLEN-1:0] bpc, tgt;
      logic rv, tk;
      bpc = pool[$urandom_range(0, 7)];
      case ($urandom_range(0, 2))
        0: tgt = bpc - ({$urandom_range(1, 64)} << 2);
        1: tgt = bpc + ({$urandom_range(0, 64)} << 2);
        default: tgt = bpc;
      endcase
      rv = ($urandom_range(0, 3) != 0);
      tk = ($urandom_range(0, 2) != 0);
      step(pool[$urandom_range(0, 7)], rv, bpc, tgt, tk);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule